// File: doc/BRIEF.md
# Programmable Shift-Add Constant Multiplier

This block multiplies an unsigned input sample by a constant. The constant is not wired into the logic. It is described at run time by a table of node descriptors. Each node is an adder or a subtracter that takes two operands from earlier results. Exactly one operand is shifted left by a small amount before the add or subtract. Operand index 0 names the raw input. Index j+1 names the result of node j.

Software-side logic writes descriptors into a shadow table. A commit strobe validates the shadow table and makes it the active one. The same strobe also captures three more settings: the chain length, the exclusive shift limit, and a final left shift. The final shift lets an even constant 2^k·C0 be built from a chain for the odd C0. A new product appears every cycle, one register after the input, with no handshake. If a committed table breaks the ordering or range rules, an error flag rises and the product reads zero until a legal table is committed.

Top module: `adder_graph_mult`

## Requirements
- R1: After reset, `prod_out` is 0 and `cfg_bad` is 1, because no legal table is active yet.
- R2: Operand index 0 selects the input. Index j+1 selects the result of node j. A node k may only use indices 0..k, and a commit in which an in-use node names a later index is rejected.
- R3: With `cfg_add`=1, a node yields (v1 << sh) + v2. A commit in which an in-use add node has `cfg_shift_first`=0 is rejected.
- R4: With `cfg_add`=0 and `cfg_shift_first`=1, a node yields (v1 << sh) - v2.
- R5: With `cfg_add`=0 and `cfg_shift_first`=0, a node yields v1 - (v2 << sh).
- R6: Every in-use node's shift must satisfy 1 <= sh < `cfg_shlim`, and `cfg_shlim` must not exceed SH_CAP (16). Any other value rejects the commit, and sh = limit-1 is accepted.
- R7: The product is the result of node `cfg_len`-1. A length of 0 or more than NODES (4) is rejected. Nodes at or beyond the length are not checked.
- R8: The chain result is shifted left by the committed `cfg_post` bits before it is output.
- R9: Descriptor writes change nothing at the output until a commit. A write in the commit cycle is not part of that commit.
- R10: A rejected commit sets `cfg_bad` and forces `prod_out` to 0. The flag holds until the next commit, and a legal commit clears it.
- R11: `prod_out` after a rising edge reflects `x_in` just before that edge, using the table committed at an earlier edge.
- R12: Node results are kept at XW+SH_CAP+1 bits, so a legal table whose true intermediate values fit that width never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write one descriptor into the shadow table |
| cfg_node | input | 2 | Node slot being written |
| cfg_add | input | 1 | 1 = add node, 0 = subtract node |
| cfg_shift_first | input | 1 | 1 = shift operand v1, 0 = shift operand v2 |
| cfg_src1 | input | 3 | Operand v1 index (0 = input, j+1 = node j) |
| cfg_src2 | input | 3 | Operand v2 index |
| cfg_shamt | input | 4 | Shift amount |
| cfg_commit | input | 1 | Validate and activate the shadow table |
| cfg_len | input | 3 | Number of nodes in use, captured on commit |
| cfg_shlim | input | 5 | Exclusive shift limit, captured on commit |
| cfg_post | input | 3 | Final left shift, captured on commit |
| x_in | input | 8 | Unsigned multiplicand |
| prod_out | output | 32 | Registered product |
| cfg_bad | output | 1 | Active table is illegal or absent |

## Verification
The no-wrap assertions assume a legal table whose true intermediate values stay non-negative and fit the node width for every input. A subtracter fed so that it goes below zero would break this. The stimulus therefore uses only chains built the way a constant-multiplication search builds them: every intermediate is a positive multiple of the input, and it stays below 2^14 times the input. The legality assertions take for granted that commits are the only way the active table changes. The illegal tables the bench commits are chosen so that each one breaks exactly one rule while `cfg_bad` masks its unchecked output.

// File: rtl/agm_pkg.sv
// Shared definitions for the adder-graph multiplier.
// Assumes: descriptor flags arrive as two raw bits (add, shift-first).
package agm_pkg;

    typedef enum logic [1:0] {
        OP_ADD       = 2'd0,
        OP_SUB_SHL_A = 2'd1,
        OP_SUB_SHL_B = 2'd2
    } op_e;

    // Map the two descriptor flags onto a node operation.
    function automatic op_e op_decode(input logic add, input logic shift_first);
        if (add)              return OP_ADD;
        else if (shift_first) return OP_SUB_SHL_A;
        else                  return OP_SUB_SHL_B;
    endfunction

endpackage

// File: rtl/agm_node.sv
// One adder/subtracter node: picks two operands from its candidate taps,
// shifts one of them and adds or subtracts.
// Assumes: candidate k sits at bits [k*W +: W]; out-of-range index reads 0.
module agm_node
    import agm_pkg::*;
#(
    parameter int W    = 25,
    parameter int SHW  = 4,
    parameter int IDXW = 3,
    parameter int NIN  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NIN*W-1:0]    cand,
    input  logic [IDXW-1:0]     src1,
    input  logic [IDXW-1:0]     src2,
    input  logic                add,
    input  logic                shift_first,
    input  logic [SHW-1:0]      shamt,
    input  logic                chk_en,
    output logic [W-1:0]        val
);
    localparam int WW = W + (1 << SHW);

    logic [W-1:0]  v1, v2;
    logic [WW-1:0] a, b, res;

    // Select operand value by index from the candidate taps.
    function automatic logic [W-1:0] pick(input logic [NIN*W-1:0] c,
                                          input logic [IDXW-1:0] idx);
        logic [W-1:0] r;
        r = '0;
        for (int k = 0; k < NIN; k++)
            if (int'(idx) == k) r = c[k*W +: W];
        return r;
    endfunction

    // Operand selection and the shift-add/subtract itself, in a wide width.
    always_comb begin
        v1 = pick(cand, src1);
        v2 = pick(cand, src2);
        a  = {{(WW-W){1'b0}}, v1};
        b  = {{(WW-W){1'b0}}, v2};
        case (op_decode(add, shift_first))
            OP_ADD:       res = (a << shamt) + b;
            OP_SUB_SHL_A: res = (a << shamt) - b;
            default:      res = a - (b << shamt);
        endcase
    end

    assign val = res[W-1:0];

    // R12: a live node on a legal table never leaves the node width.
    assert_no_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> (res[WW-1:W] == '0));

endmodule

// File: rtl/agm_cfg_table.sv
// Shadow and active descriptor tables. Commit validates the shadow table
// and copies it to the active one together with length, limit and post-shift.
// Assumes: a write in the commit cycle lands in the shadow table only.
module agm_cfg_table #(
    parameter int NODES  = 4,
    parameter int SH_CAP = 16,
    parameter int SHW    = 4,
    parameter int LIMW   = 5,
    parameter int IDXW   = 3,
    parameter int AW     = 2,
    parameter int LENW   = 3,
    parameter int PSW    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [AW-1:0]               waddr,
    input  logic                        wadd,
    input  logic                        wshf,
    input  logic [IDXW-1:0]             wsrc1,
    input  logic [IDXW-1:0]             wsrc2,
    input  logic [SHW-1:0]              wsh,
    input  logic                        commit,
    input  logic [LENW-1:0]             clen,
    input  logic [LIMW-1:0]             clim,
    input  logic [PSW-1:0]              cpost,
    output logic [NODES-1:0]            act_add,
    output logic [NODES-1:0]            act_shf,
    output logic [NODES-1:0][IDXW-1:0]  act_src1,
    output logic [NODES-1:0][IDXW-1:0]  act_src2,
    output logic [NODES-1:0][SHW-1:0]   act_sh,
    output logic [LENW-1:0]             act_len,
    output logic [PSW-1:0]              act_post,
    output logic                        bad
);
    logic [NODES-1:0]           sh_add, sh_shf;
    logic [NODES-1:0][IDXW-1:0] sh_src1, sh_src2;
    logic [NODES-1:0][SHW-1:0]  sh_sh;
    logic [LIMW-1:0]            act_lim;
    logic                       table_ok;

    // Shadow table: accept descriptor writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_add <= '0; sh_shf <= '0; sh_src1 <= '0; sh_src2 <= '0; sh_sh <= '0;
        end else if (we) begin
            sh_add[waddr]  <= wadd;
            sh_shf[waddr]  <= wshf;
            sh_src1[waddr] <= wsrc1;
            sh_src2[waddr] <= wsrc2;
            sh_sh[waddr]   <= wsh;
        end
    end

    // Legality of the shadow table against the commit-time settings.
    always_comb begin
        table_ok = (int'(clen) >= 1) && (int'(clen) <= NODES) && (int'(clim) <= SH_CAP);
        for (int j = 0; j < NODES; j++) begin
            if (j < int'(clen)) begin
                if (int'(sh_src1[j]) > j || int'(sh_src2[j]) > j) table_ok = 1'b0;
                if (sh_sh[j] == '0 || {1'b0, sh_sh[j]} >= clim)    table_ok = 1'b0;
                if (sh_add[j] && !sh_shf[j])                       table_ok = 1'b0;
            end
        end
    end

    // Active table and error flag: replaced only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_add <= '0; act_shf <= '0; act_src1 <= '0; act_src2 <= '0; act_sh <= '0;
            act_len <= LENW'(1); act_post <= '0; act_lim <= '0; bad <= 1'b1;
        end else if (commit) begin
            act_add  <= sh_add;  act_shf  <= sh_shf;
            act_src1 <= sh_src1; act_src2 <= sh_src2; act_sh <= sh_sh;
            act_len  <= clen;    act_post <= cpost;   act_lim <= clim;
            bad      <= !table_ok;
        end
    end

    // R9: the active table only moves on a commit.
    assert_table_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_sh) && $stable(act_src1) && $stable(act_src2)
                     && $stable(act_len) && $stable(act_post)));

    // R7: a clean flag implies a usable chain length.
    assert_len_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bad |-> (int'(act_len) >= 1 && int'(act_len) <= NODES));

    for (genvar j = 0; j < NODES; j++) begin : g_chk
        // R2: live nodes only reference earlier results.
        assert_src_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!bad && j < int'(act_len)) |-> (int'(act_src1[j]) <= j && int'(act_src2[j]) <= j));
        // R6: live shifts sit inside the committed range.
        assert_shift_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!bad && j < int'(act_len)) |-> (act_sh[j] != '0 && {1'b0, act_sh[j]} < act_lim));
        // R3: live add nodes shift their first operand.
        assert_add_shift_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!bad && j < int'(act_len) && act_add[j]) |-> act_shf[j]);
    end

endmodule

// File: rtl/agm_chain.sv
// Combinational node chain: builds each node's tap vector from the input and
// earlier nodes, picks the last live node and applies the post-shift.
// Assumes: node j sees taps 0..j only (input, then nodes 0..j-1).
module agm_chain #(
    parameter int XW    = 8,
    parameter int W     = 25,
    parameter int SHW   = 4,
    parameter int IDXW  = 3,
    parameter int NODES = 4,
    parameter int LENW  = 3,
    parameter int PSW   = 3,
    parameter int OUTW  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [XW-1:0]               x_in,
    input  logic [NODES-1:0]            n_add,
    input  logic [NODES-1:0]            n_shf,
    input  logic [NODES-1:0][IDXW-1:0]  n_src1,
    input  logic [NODES-1:0][IDXW-1:0]  n_src2,
    input  logic [NODES-1:0][SHW-1:0]   n_sh,
    input  logic [LENW-1:0]             len,
    input  logic [PSW-1:0]              post,
    input  logic                        bad,
    output logic [OUTW-1:0]             prod
);
    for (genvar j = 0; j < NODES; j++) begin : g_node
        logic [(j+1)*W-1:0] cand;
        logic [W-1:0]       val;
        logic               live;

        if (j == 0) begin : g_first
            assign cand = {{(W-XW){1'b0}}, x_in};
        end else begin : g_rest
            assign cand = {g_node[j-1].val, g_node[j-1].cand};
        end

        assign live = !bad && (j < int'(len));

        agm_node #(.W(W), .SHW(SHW), .IDXW(IDXW), .NIN(j+1)) u_node (
            .clk(clk), .rst_n(rst_n), .cand(cand),
            .src1(n_src1[j]), .src2(n_src2[j]),
            .add(n_add[j]), .shift_first(n_shf[j]), .shamt(n_sh[j]),
            .chk_en(live), .val(val)
        );
    end

    logic [(NODES+1)*W-1:0] taps;
    logic [W-1:0]           last;

    assign taps = {g_node[NODES-1].val, g_node[NODES-1].cand};

    // Pick the result of node len-1 and apply the final shift.
    always_comb begin
        last = '0;
        for (int k = 1; k <= NODES; k++)
            if (int'(len) == k) last = taps[k*W +: W];
        prod = {{(OUTW-W){1'b0}}, last} << post;
    end

endmodule

// File: rtl/adder_graph_mult.sv
// Top: run-time programmable shift-add constant multiplier with one output
// register. Illegal committed tables force the product to zero.
// Assumes: legal tables keep every intermediate non-negative and in width.
module adder_graph_mult #(
    parameter int XW     = 8,
    parameter int NODES  = 4,
    parameter int SH_CAP = 16,
    parameter int PSW    = 3,
    localparam int SHW   = $clog2(SH_CAP),
    localparam int LIMW  = $clog2(SH_CAP + 1),
    localparam int IDXW  = $clog2(NODES + 1),
    localparam int AW    = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int LENW  = $clog2(NODES + 1),
    localparam int W     = XW + SH_CAP + 1,
    localparam int OUTW  = W + (1 << PSW) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_node,
    input  logic              cfg_add,
    input  logic              cfg_shift_first,
    input  logic [IDXW-1:0]   cfg_src1,
    input  logic [IDXW-1:0]   cfg_src2,
    input  logic [SHW-1:0]    cfg_shamt,
    input  logic              cfg_commit,
    input  logic [LENW-1:0]   cfg_len,
    input  logic [LIMW-1:0]   cfg_shlim,
    input  logic [PSW-1:0]    cfg_post,
    input  logic [XW-1:0]     x_in,
    output logic [OUTW-1:0]   prod_out,
    output logic              cfg_bad
);
    logic [NODES-1:0]           a_add, a_shf;
    logic [NODES-1:0][IDXW-1:0] a_src1, a_src2;
    logic [NODES-1:0][SHW-1:0]  a_sh;
    logic [LENW-1:0]            a_len;
    logic [PSW-1:0]             a_post;
    logic [OUTW-1:0]            prod_c;

    agm_cfg_table #(.NODES(NODES), .SH_CAP(SH_CAP), .SHW(SHW), .LIMW(LIMW),
                    .IDXW(IDXW), .AW(AW), .LENW(LENW), .PSW(PSW)) u_table (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_node),
        .wadd(cfg_add), .wshf(cfg_shift_first), .wsrc1(cfg_src1), .wsrc2(cfg_src2),
        .wsh(cfg_shamt), .commit(cfg_commit), .clen(cfg_len), .clim(cfg_shlim),
        .cpost(cfg_post), .act_add(a_add), .act_shf(a_shf), .act_src1(a_src1),
        .act_src2(a_src2), .act_sh(a_sh), .act_len(a_len), .act_post(a_post),
        .bad(cfg_bad)
    );

    agm_chain #(.XW(XW), .W(W), .SHW(SHW), .IDXW(IDXW), .NODES(NODES),
                .LENW(LENW), .PSW(PSW), .OUTW(OUTW)) u_chain (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .n_add(a_add), .n_shf(a_shf),
        .n_src1(a_src1), .n_src2(a_src2), .n_sh(a_sh), .len(a_len),
        .post(a_post), .bad(cfg_bad), .prod(prod_c)
    );

    // Output register: product, or zero while the table is illegal.
    always_ff @(posedge clk) begin
        if (!rst_n)       prod_out <= '0;
        else if (cfg_bad) prod_out <= '0;
        else              prod_out <= prod_c;
    end

    // R10: an illegal table yields a zero product on the next edge.
    assert_zero_when_bad_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |=> (prod_out == '0));

    // R10: the error flag only changes on a commit.
    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_commit |=> $stable(cfg_bad));

endmodule

// File: tb/adder_graph_mult_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver pushes expected products per input sample, a
// monitor pops and compares one cycle later.
module adder_graph_mult_tb_top;
    localparam int NODES = 4;
    localparam int SH_CAP = 16;
    localparam int OUTW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_add = 1'b0, cfg_shift_first = 1'b0, cfg_commit = 1'b0;
    logic [1:0] cfg_node = '0;
    logic [2:0] cfg_src1 = '0, cfg_src2 = '0, cfg_len = '0, cfg_post = '0;
    logic [3:0] cfg_shamt = '0;
    logic [4:0] cfg_shlim = '0;
    logic [7:0] x_in = '0;
    logic [OUTW-1:0] prod_out;
    logic cfg_bad;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // shadow and committed model state
    int s_add[NODES], s_shf[NODES], s_s1[NODES], s_s2[NODES], s_sh[NODES];
    int m_add[NODES], m_shf[NODES], m_s1[NODES], m_s2[NODES], m_sh[NODES];
    int m_len = 1, m_post = 0;
    bit m_bad = 1;

    longint exp_q[$];
    string  tag_q[$];

    always #10 clk = ~clk;

    adder_graph_mult dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_node(cfg_node),
        .cfg_add(cfg_add), .cfg_shift_first(cfg_shift_first), .cfg_src1(cfg_src1),
        .cfg_src2(cfg_src2), .cfg_shamt(cfg_shamt), .cfg_commit(cfg_commit),
        .cfg_len(cfg_len), .cfg_shlim(cfg_shlim), .cfg_post(cfg_post),
        .x_in(x_in), .prod_out(prod_out), .cfg_bad(cfg_bad)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint model(input longint x);
        longint t[NODES+1];
        longint v1, v2, r;
        if (m_bad) return 0;
        t[0] = x;
        for (int j = 0; j < m_len; j++) begin
            v1 = t[m_s1[j]];
            v2 = t[m_s2[j]];
            if (m_add[j] != 0)      r = (v1 << m_sh[j]) + v2;
            else if (m_shf[j] != 0) r = (v1 << m_sh[j]) - v2;
            else                    r = v1 - (v2 << m_sh[j]);
            t[j+1] = r;
        end
        return (t[m_len] << m_post) & 64'hFFFF_FFFF;
    endfunction

    function automatic bit legal(input int len, input int lim);
        if (len < 1 || len > NODES || lim > SH_CAP) return 0;
        for (int j = 0; j < len; j++) begin
            if (s_s1[j] > j || s_s2[j] > j) return 0;
            if (s_sh[j] < 1 || s_sh[j] >= lim) return 0;
            if (s_add[j] != 0 && s_shf[j] == 0) return 0;
        end
        return 1;
    endfunction

    task automatic wr(input int n, input int add, input int shf,
                      input int s1, input int s2, input int sh);
        @(negedge clk);
        cfg_we = 1; cfg_node = 2'(n); cfg_add = add[0]; cfg_shift_first = shf[0];
        cfg_src1 = 3'(s1); cfg_src2 = 3'(s2); cfg_shamt = 4'(sh);
        @(negedge clk);
        cfg_we = 0;
        s_add[n] = add; s_shf[n] = shf; s_s1[n] = s1; s_s2[n] = s2; s_sh[n] = sh;
    endtask

    task automatic commit(input int len, input int lim, input int post, input string tag);
        @(negedge clk);
        cfg_commit = 1; cfg_len = 3'(len); cfg_shlim = 5'(lim); cfg_post = 3'(post);
        @(negedge clk);
        cfg_commit = 0;
        m_bad = !legal(len, lim);
        m_add = s_add; m_shf = s_shf; m_s1 = s_s1; m_s2 = s_s2; m_sh = s_sh;
        m_len = len; m_post = post;
        check({tag, " flag"}, longint'(cfg_bad), longint'(m_bad));
    endtask

    // driver: present one sample and queue its expected product
    task automatic step(input int x, input string tag);
        @(negedge clk);
        x_in = 8'(x);
        exp_q.push_back(model(longint'(x)));
        tag_q.push_back(tag);
    endtask

    // monitor: compare each product one edge after its sample
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) check(tag_q.pop_front(), longint'(prod_out), exp_q.pop_front());
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < NODES; j++) begin
            s_add[j] = 0; s_shf[j] = 0; s_s1[j] = 0; s_s2[j] = 0; s_sh[j] = 0;
            m_add[j] = 0; m_shf[j] = 0; m_s1[j] = 0; m_s2[j] = 0; m_sh[j] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset product", longint'(prod_out), 0);
        check("R1 reset flag", longint'(cfg_bad), 1);

        // chain for 12345: 7x, 25x, 455x, 12345x (R2 R3 R4)
        wr(0, 0, 1, 0, 0, 3);
        wr(1, 0, 1, 0, 1, 5);
        wr(2, 1, 1, 1, 1, 6);
        wr(3, 0, 1, 2, 3, 9);
        commit(4, 15, 0, "R10 legal commit");
        step(0, "R11 x=0");
        step(1, "R2 R3 R4 x=1");
        step(255, "R12 x=255");
        step(37, "R7 x=37");
        step(200, "R11 back-to-back");

        // R9: shadow writes without commit leave the product alone
        wr(3, 0, 0, 1, 0, 2);
        step(3, "R9 uncommitted write");
        check("R9 flag unchanged", longint'(cfg_bad), 0);

        // 17x then 17x-4x=13x, post-shift 3 gives 104x (R5 R8)
        wr(0, 1, 1, 0, 0, 4);
        wr(1, 0, 0, 1, 0, 2);
        commit(2, 16, 3, "R8 commit");
        step(11, "R5 R8 x=11");
        step(255, "R5 R8 x=255");

        // length 1 takes node 0 only (R7)
        commit(1, 16, 0, "R7 commit len1");
        step(9, "R7 len1 x=9");

        // R6: shift at limit-1 accepted, at limit rejected
        commit(1, 5, 0, "R6 sh=lim-1");
        step(4, "R6 boundary ok");
        commit(1, 4, 0, "R6 sh=lim");
        step(4, "R6 rejected zero");
        step(77, "R10 still zero");
        check("R10 flag held", longint'(cfg_bad), 1);
        commit(1, 17, 0, "R6 lim over cap");

        // R2: forward reference rejected
        wr(1, 0, 0, 2, 0, 2);
        commit(2, 16, 0, "R2 forward ref");
        step(5, "R2 zero");
        wr(1, 0, 0, 1, 0, 2);

        // R3: add node shifting second operand rejected
        wr(0, 1, 0, 0, 0, 4);
        commit(2, 16, 0, "R3 add shf2");
        step(5, "R3 zero");
        wr(0, 1, 1, 0, 0, 4);

        // R7: zero length rejected, then legal commit clears the flag
        commit(0, 16, 0, "R7 len0");
        step(6, "R7 zero");
        commit(2, 16, 1, "R10 recover");
        step(6, "R10 recovered");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule